// File: doc/BRIEF.md
# Timed Protection Byte Access Controller

This block sits beside a CPU's self-programming logic and guards access to the chip's protection bytes. Software first writes a command code into a small control register. That write opens a short window. A store-program strobe that arrives inside the window burns boot-lock bits from a data byte. A load-program strobe that arrives inside the window returns one of three protection bytes, chosen by a 16-bit pointer.

The window closes by itself once a strobe has been served. It also closes after a fixed number of idle cycles. Load strobes get a shorter window than store strobes. While an EEPROM write is busy, the register cannot be written and strobes are not served. Any load strobe that the block does not serve is left to the normal program-memory read path, and `rd_hit` stays low for it.

Top module: `prot_cmd_ctrl`

## Requirements
- R1: After reset, `lock_bits` is 8'hFF, no window is open, `rd_hit` is 0 and `rd_data` is 8'h00.
- R2: A control write (`ctl_we` with `ee_busy` low) opens a window only if `ctl_wdata[6:0]` equals 7'b0001001. Bit 3 is the lock-select bit and bit 0 is the enable bit. Bit 7 is ignored. A write of any other code closes an open window.
- R3: A store strobe is served only in the first four cycles after the opening write. A store strobe in the fifth cycle or later leaves `lock_bits` unchanged.
- R4: A load strobe is served only in the first three cycles after the opening write. In those cycles `rd_hit` is 1 in the same cycle as the strobe. In the fourth cycle `rd_hit` stays 0.
- R5: For a served load, the pointer selects the result. Pointer 16'h0001 returns the lock byte, 16'h0000 returns FUSE_LO_RST, 16'h0003 returns FUSE_HI_RST, and any other pointer returns 8'hFF.
- R6: A served store clears each `lock_bits` bit in 5..2 whose `wdata` bit is 0. Data bits 7..6 and 1..0 and the pointer have no effect. Bits can never return from 0 to 1.
- R7: A served strobe closes the window, so a second strobe in the same window is not served.
- R8: While `ee_busy` is 1, control writes are ignored, no strobe is served, and the window keeps counting.
- R9: A load strobe outside a window gives `rd_hit` = 0 and `rd_data` = 8'h00.
- R10: A valid control write while a window is open restarts the cycle count from zero.
- R11: When a control write and a served store strobe fall in the same cycle, the store takes effect and the write opens a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| st_strobe | input | 1 | Store-program strobe |
| ld_strobe | input | 1 | Load-program strobe |
| ptr | input | 16 | Pointer that selects the protection byte |
| wdata | input | 8 | Data byte for lock programming |
| ee_busy | input | 1 | An EEPROM write is in progress |
| rd_data | output | 8 | Protection byte returned for a served load |
| rd_hit | output | 1 | The load strobe in this cycle was served by the block |
| lock_bits | output | 8 | Stored lock byte |

## Verification
A store strobe and a control-register rewrite can land in the same cycle. The bench provokes this in the last cycle of a store window: it drives a valid command together with a store strobe whose data clears one boot-lock bit. It then judges two results. The lock byte must lose exactly that bit on the next edge. A load strobe one cycle later must still be served, which shows that the write restarted the window and was not lost to the store that closed the old one.

// File: rtl/prot_cmd_ctrl.sv
module prot_cmd_ctrl #(
  parameter int         LD_WIN      = 3,
  parameter int         ST_WIN      = 4,
  parameter logic [6:0] CMD_LOCK    = 7'b0001001,
  parameter logic [7:0] FUSE_LO_RST = 8'h62,
  parameter logic [7:0] FUSE_HI_RST = 8'hDF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  input  logic        st_strobe,
  input  logic        ld_strobe,
  input  logic [15:0] ptr,
  input  logic [7:0]  wdata,
  input  logic        ee_busy,
  output logic [7:0]  rd_data,
  output logic        rd_hit,
  output logic [7:0]  lock_bits
);
  localparam int            CW     = $clog2(ST_WIN + 1);
  localparam logic [CW-1:0] LD_LIM = CW'(LD_WIN);
  localparam logic [CW-1:0] ST_LIM = CW'(ST_WIN);
  localparam logic [CW-1:0] LAST   = CW'(ST_WIN - 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [7:0]    lk;

  wire cmd_wr  = ctl_we && !ee_busy;
  wire cmd_arm = (ctl_wdata & 8'h7F) == {1'b0, CMD_LOCK};
  wire ld_hit  = ld_strobe && armed && (cnt < LD_LIM) && !ee_busy;
  wire st_hit  = st_strobe && armed && (cnt < ST_LIM) && !ee_busy;

  logic [7:0] sel_byte;
  always_comb begin
    case (ptr)
      16'h0000: sel_byte = FUSE_LO_RST;
      16'h0001: sel_byte = lk;
      16'h0003: sel_byte = FUSE_HI_RST;
      default:  sel_byte = 8'hFF;
    endcase
  end

  assign rd_hit    = ld_hit;
  assign rd_data   = ld_hit ? sel_byte : 8'h00;
  assign lock_bits = lk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      lk    <= 8'hFF;
    end else begin
      if (st_hit) lk <= lk & (wdata | 8'hC3);
      if (cmd_wr) begin
        armed <= cmd_arm;
        cnt   <= '0;
      end else begin
        if (armed) cnt <= cnt + 1'b1;
        if (ld_hit || st_hit || (armed && cnt == LAST)) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prot_cmd_ctrl_chk.sv
module prot_cmd_ctrl_chk #(
  parameter int         LD_WIN   = 3,
  parameter logic [6:0] CMD_LOCK = 7'b0001001
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic       st_strobe,
  input logic       ld_strobe,
  input logic       ee_busy,
  input logic       rd_hit,
  input logic [7:0] lock_bits
);
  logic [3:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= 4'hF;
    else if (ctl_we && !ee_busy && ctl_wdata[6:0] == CMD_LOCK) since <= 4'h0;
    else if (since != 4'hF) since <= since + 4'h1;
  end

  // R8
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (ld_strobe && !ee_busy));
  // R4
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (since < 4'(LD_WIN)));
  // R6
  lock_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_bits & ~$past(lock_bits)) == 8'h00));
  // R6
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_strobe || ee_busy) |=> $stable(lock_bits));
  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !ctl_we) |=> !rd_hit);
endmodule

bind prot_cmd_ctrl prot_cmd_ctrl_chk #(.LD_WIN(LD_WIN), .CMD_LOCK(CMD_LOCK)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .st_strobe(st_strobe), .ld_strobe(ld_strobe), .ee_busy(ee_busy),
  .rd_hit(rd_hit), .lock_bits(lock_bits));

// File: tb/prot_cmd_ctrl_tb_top.sv
module prot_cmd_ctrl_tb_top;
  localparam logic [7:0] FLO = 8'h62;
  localparam logic [7:0] FHI = 8'hDF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, st_strobe = 0, ld_strobe = 0, ee_busy = 0;
  logic [7:0] ctl_wdata = 0, wdata = 0;
  logic [15:0] ptr = 0;
  logic [7:0] rd_data, lock_bits;
  logic rd_hit;

  always #2 clk = ~clk;

  prot_cmd_ctrl #(.FUSE_LO_RST(FLO), .FUSE_HI_RST(FHI)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .st_strobe(st_strobe), .ld_strobe(ld_strobe), .ptr(ptr), .wdata(wdata),
    .ee_busy(ee_busy), .rd_data(rd_data), .rd_hit(rd_hit), .lock_bits(lock_bits));

  typedef struct { string req; logic hit; logic [7:0] data; logic [7:0] lk; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic m_arm = 0;
  int   m_cnt = 0;
  logic [7:0] m_lk = 8'hFF;

  task automatic cyc(input logic we, input logic [7:0] wd, input logic st, input logic ld,
                     input logic [15:0] p, input logic [7:0] d, input logic busy, input string req);
    item_t it;
    logic hl, hs;
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; st_strobe = st; ld_strobe = ld;
    ptr = p; wdata = d; ee_busy = busy;
    hl = ld && m_arm && m_cnt < 3 && !busy;
    hs = st && m_arm && m_cnt < 4 && !busy;
    it.req = req; it.hit = hl; it.lk = m_lk;
    it.data = !hl ? 8'h00 : (p == 16'h0000) ? FLO : (p == 16'h0001) ? m_lk :
              (p == 16'h0003) ? FHI : 8'hFF;
    sbq.push_back(it);
    if (hs) m_lk = m_lk & (d | 8'hC3);
    if (we && !busy) begin
      m_arm = (wd[6:0] == 7'b0001001); m_cnt = 0;
    end else begin
      if (hl || hs || (m_arm && m_cnt == 3)) m_arm = 0;
      else if (m_arm) m_cnt = m_cnt + 1;
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 16'h0, 8'h0, 0, req);
  endtask
  task automatic arm(input string req);
    cyc(1, 8'h09, 0, 0, 16'h0, 8'h0, 0, req);
  endtask
  task automatic rd(input logic [15:0] p, input string req);
    cyc(0, 0, 0, 1, p, 8'h0, 0, req);
  endtask
  task automatic wr(input logic [7:0] d, input string req);
    cyc(0, 0, 1, 0, 16'h1234, d, 0, req);
  endtask

  always begin
    @(negedge clk);
    #1;
    while (sbq.size() > 0) begin
      item_t e;
      e = sbq.pop_front();
      checks++;
      if (rd_hit !== e.hit || rd_data !== e.data || lock_bits !== e.lk) begin
        fails++;
        $display("FAIL %s: hit/data/lock actual %b/%h/%h expected %b/%h/%h",
                 e.req, rd_hit, rd_data, lock_bits, e.hit, e.data, e.lk);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(16'h0001, "R1");
    arm("R2"); rd(16'h0001, "R4"); rd(16'h0001, "R7");
    cyc(1, 8'h89, 0, 0, 0, 0, 0, "R2"); idle(1, "R5"); rd(16'h0000, "R5");
    arm("R5"); idle(2, "R5"); rd(16'h0003, "R5");
    arm("R5"); rd(16'h0002, "R5");
    arm("R4"); idle(3, "R4"); rd(16'h0001, "R4");
    arm("R3"); idle(3, "R3"); wr(8'h38, "R6"); idle(1, "R6");
    arm("R3"); idle(4, "R3"); wr(8'h00, "R3"); idle(1, "R3");
    arm("R6"); wr(8'hFF, "R6"); idle(1, "R6");
    arm("R6"); wr(8'hEF, "R6"); wr(8'h00, "R7"); idle(1, "R7");
    arm("R2"); cyc(1, 8'h01, 0, 0, 0, 0, 0, "R2"); rd(16'h0001, "R2");
    cyc(1, 8'h09, 0, 0, 0, 0, 1, "R8"); rd(16'h0001, "R8");
    arm("R8"); cyc(0, 0, 1, 0, 0, 8'h00, 1, "R8"); cyc(0, 0, 0, 1, 16'h1, 0, 1, "R8");
    rd(16'h0001, "R8");
    arm("R10"); idle(2, "R10"); arm("R10"); idle(2, "R10"); rd(16'h0001, "R10");
    arm("R10"); idle(3, "R10"); arm("R10"); idle(3, "R10"); wr(8'h1C, "R10"); idle(1, "R10");
    arm("R11"); idle(3, "R11"); cyc(1, 8'h09, 1, 0, 0, 8'h34, 0, "R11");
    idle(1, "R11"); rd(16'h0001, "R11");
    idle(5, "R9"); rd(16'h0000, "R9");
    idle(2, "R9");
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run actual hung expected complete");
    end
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule